// File: doc/BRIEF.md
# Two-Wire Bus Write-Only Slave Receiver

This block is the slave end of an open-drain two-wire serial bus (clock line plus data line) for transfers in the write direction. It oversamples both lines with the system clock, recognises START and STOP conditions, and gathers the first byte after a START as a seven-bit address plus a direction bit. When the address equals `own_addr` and the direction bit asks for a write, it acknowledges and then collects data bytes. Each byte is handed to local logic on `rx_data` with a one-cycle `rx_valid` strobe.

Local logic paces the transfer in two ways. While `rx_ready` is low at the end of an acknowledge slot, the slave holds the clock line low. The bus master then cannot start the next byte until the consumer is ready. When `rx_last` is high as a byte completes, that byte is still delivered, but it is refused with a NACK and the slave drops out of the transfer. Both lines are driven only by pulling low: `scl_oe` and `sda_oe` high mean the pad pulls the line low. With both low the line is released.

Top module: `i2c_wr_slave`

## Requirements
- R1: While reset is held and just after it is released, `sda_oe`, `scl_oe` and `rx_valid` are all low.
- R2: When the first byte after a START carries `own_addr` in its upper seven bits (MSB first) and 0 in its last bit (write), the slave pulls SDA low for the whole high phase of the ninth clock. The slave changes `sda_oe` only while SCL is low.
- R3: If the address bits differ from `own_addr`, or the direction bit is 1 (read), no acknowledge is given. Until the next START, no byte is delivered and no line is driven.
- R4: Every received data byte appears on `rx_data` with its first bus bit as bit 7, and `rx_valid` is high for exactly one clock cycle per byte, after the eighth data bit.
- R5: A data byte that completes while `rx_last` is low is acknowledged (SDA low in the ninth clock).
- R6: A data byte that completes while `rx_last` is high is delivered but receives a NACK. Later bytes in that transfer are neither acknowledged nor delivered.
- R7: If `rx_ready` is low when the acknowledge slot ends, the slave holds SCL low (`scl_oe` high) until `rx_ready` goes high, and then releases it. It never holds SCL and SDA at the same time.
- R8: The slave only starts holding SCL while the clock line is already low. It never pulls the clock down during a high phase.
- R9: A repeated START, even in the middle of a data byte, discards the partial byte and restarts address matching.
- R10: After a STOP the slave is idle. Clock pulses without a new START are neither acknowledged nor delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Clock line level as seen at the pad |
| sda_i | input | 1 | Data line level as seen at the pad |
| scl_oe | output | 1 | High to pull the clock line low (stretch) |
| sda_oe | output | 1 | High to pull the data line low (acknowledge) |
| own_addr | input | 7 | Configured seven-bit slave address |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_data` |
| rx_ready | input | 1 | Consumer can take the next byte; low stretches the clock |
| rx_last | input | 1 | The byte now completing fills the consumer; refuse further data |

## Verification
The bench plays a bus master that respects clock stretching. It goes after the address that is right except for a read direction bit. A slave that ignored that bit would acknowledge and collect bytes it must not take. A repeated START after four data bits checks that the partial byte is thrown away: a slave that kept its bit count would lose byte alignment and deliver a corrupt byte. The bench refuses a byte with `rx_last` and then sends more bytes. A slave that only suppressed the acknowledge, but kept delivering, would show extra strobes. The bench also clocks a whole byte after a STOP with no new START, which a slave that never returned to idle would accept. Random transfers, some to a foreign address, are checked byte for byte against a bench-side model.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_HOLD,
    ST_SKIP
  } rx_state_e;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '1;
        else        pipe[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '1;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events
  import i2cs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_s,
  input  logic    sda_s,
  output bus_ev_t ev
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    ev.scl_rise = scl_s & ~scl_q;
    ev.scl_fall = ~scl_s & scl_q;
    ev.start    = scl_s & scl_q & sda_q & ~sda_s;
    ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/i2cs_shifter.sv
module i2cs_shifter #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [W-1:0]  word,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] FULL = CW'(W);

  logic [W-1:0]  word_d;
  logic [CW-1:0] count_d;

  always_comb begin
    word_d  = word;
    count_d = count;
    if (clear) begin
      word_d  = '0;
      count_d = '0;
    end else if (shift_en) begin
      word_d = {word[W-2:0], bit_in};
      if (count != FULL) count_d = count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      count <= '0;
    end else if (clear || shift_en) begin
      word  <= word_d;
      count <= count_d;
    end
  end

endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave
  import i2cs_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic              rx_last
);

  localparam int SH_W = (DATA_W > ADDR_W) ? DATA_W : ADDR_W + 1;
  localparam int CW   = $clog2(SH_W + 1);
  localparam logic [CW-1:0] ADDR_BITS = CW'(ADDR_W + 1);
  localparam logic [CW-1:0] DATA_BITS = CW'(DATA_W);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // line conditioning and event detection
  logic [1:0] lines_s;
  bus_ev_t    ev;

  i2cs_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({scl_i, sda_i}),
    .q     (lines_s)
  );

  i2cs_bus_events u_events (
    .clk   (clk),
    .rst_n (rst_int_n),
    .scl_s (lines_s[1]),
    .sda_s (lines_s[0]),
    .ev    (ev)
  );

  // bit collector
  logic            sh_clear;
  logic            sh_shift;
  logic [SH_W-1:0] sh_word;
  logic [CW-1:0]   sh_count;

  i2cs_shifter #(.W(SH_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clear    (sh_clear),
    .shift_en (sh_shift),
    .bit_in   (lines_s[0]),
    .word     (sh_word),
    .count    (sh_count)
  );

  // control
  rx_state_e         state_q, state_d;
  logic              sda_d, scl_d, nack_q, nack_d, valid_d;
  logic [DATA_W-1:0] data_d;
  logic              addr_done, data_done, addr_hit;

  assign addr_done = (sh_count == ADDR_BITS);
  assign data_done = (sh_count == DATA_BITS);
  assign addr_hit  = (sh_word[ADDR_W:1] == own_addr) && !sh_word[0];

  always_comb begin
    state_d  = state_q;
    sda_d    = sda_oe;
    scl_d    = scl_oe;
    nack_d   = nack_q;
    valid_d  = 1'b0;
    data_d   = rx_data;
    sh_clear = 1'b0;
    sh_shift = 1'b0;
    if (ev.start) begin
      state_d  = ST_ADDR;
      sda_d    = 1'b0;
      scl_d    = 1'b0;
      sh_clear = 1'b1;
    end else if (ev.stop) begin
      state_d = ST_IDLE;
      sda_d   = 1'b0;
      scl_d   = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR: begin
          if (ev.scl_rise && !addr_done) begin
            sh_shift = 1'b1;
          end else if (ev.scl_fall && addr_done) begin
            if (addr_hit) begin
              state_d = ST_ADDR_ACK;
              sda_d   = 1'b1;
              nack_d  = 1'b0;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_DATA: begin
          if (ev.scl_rise && !data_done) begin
            sh_shift = 1'b1;
          end else if (ev.scl_fall && data_done) begin
            state_d = ST_DATA_ACK;
            valid_d = 1'b1;
            data_d  = sh_word[DATA_W-1:0];
            nack_d  = rx_last;
            sda_d   = !rx_last;
          end
        end
        ST_ADDR_ACK, ST_DATA_ACK: begin
          if (ev.scl_fall) begin
            sda_d    = 1'b0;
            sh_clear = 1'b1;
            if (nack_q && (state_q == ST_DATA_ACK)) begin
              state_d = ST_SKIP;
            end else if (!rx_ready) begin
              state_d = ST_HOLD;
              scl_d   = 1'b1;
            end else begin
              state_d = ST_DATA;
            end
          end
        end
        ST_HOLD: begin
          if (rx_ready) begin
            state_d = ST_DATA;
            scl_d   = 1'b0;
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= ST_IDLE;
      sda_oe   <= 1'b0;
      scl_oe   <= 1'b0;
      nack_q   <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      state_q  <= state_d;
      sda_oe   <= sda_d;
      scl_oe   <= scl_d;
      nack_q   <= nack_d;
      rx_valid <= valid_d;
      if (valid_d) rx_data <= data_d;
    end
  end

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic scl_oe,
  input logic rx_valid,
  input logic rx_ready
);

  AST_ACK_EDGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe)); // R2

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R4

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !rx_ready) |=> scl_oe); // R7

  AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_oe && sda_oe)); // R7

  AST_STRETCH_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !$past(scl_i)); // R8

endmodule

bind i2c_wr_slave i2cs_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .scl_oe   (scl_oe),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready)
);

// File: tb/tb_i2c_wr_slave.sv
module tb_i2c_wr_slave;

  localparam logic [6:0] OWN = 7'h5A;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic rx_ready = 1'b1;
  logic rx_last = 1'b0;
  logic scl_oe, sda_oe, rx_valid;
  logic [7:0] rx_data;

  wire scl_line = scl_m & ~scl_oe;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  int n_got = 0;
  int r8_viol = 0;
  logic [7:0] got [256];
  logic prev_scl = 1'b1;
  logic prev_oe = 1'b0;

  always #4 clk = ~clk;

  i2c_wr_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_last(rx_last)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid && n_got < 256) begin
      got[n_got] = rx_data;
      n_got++;
    end
    if (scl_oe && !prev_oe && prev_scl) r8_viol++;
    prev_scl = scl_line;
    prev_oe  = scl_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(Q);
    scl_up(); wq(2*Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic get_ack(output bit a);
    sda_m = 1'b1; wq(Q);
    scl_up(); wq(Q);
    a = !sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit a);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    get_ack(a);
  endtask

  task automatic bus_start();
    if (!scl_m) begin
      sda_m = 1'b1; wq(Q);
      scl_up(); wq(Q);
    end
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_up(); wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  function automatic bit addr_ok(input logic [6:0] a, input bit rw);
    return (a == OWN) && !rw;
  endfunction

  // one write transfer; last_idx < 0 means rx_last never raised
  task automatic run_txn(input logic [6:0] a, input bit rw, input int nb, input int last_idx);
    bit ack;
    int base, k;
    bit hit;
    logic [7:0] exp_b [8];
    logic [7:0] d;
    base = n_got; k = 0;
    hit = addr_ok(a, rw);
    bus_start();
    send_byte({a, rw}, ack);
    chk(hit ? "R2 address acknowledged" : "R3 address refused", ack, hit);
    for (int i = 0; i < nb; i++) begin
      bit acc;
      d = 8'($urandom);
      rx_last = (i == last_idx);
      send_byte(d, ack);
      rx_last = 1'b0;
      acc = hit && (last_idx < 0 || i <= last_idx);
      if (acc) begin exp_b[k] = d; k++; end
      if (hit && i == last_idx) chk("R6 filling byte NACKed", ack, 0);
      else chk(acc ? "R5 data byte acked" : "R6 later byte refused", ack, acc && i != last_idx);
    end
    bus_stop();
    chk("R4 delivered byte count", n_got - base, k);
    for (int i = 0; i < k; i++) chk("R4 delivered byte value", got[base + i], exp_b[i]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired, R1-related progress stalled actual=0 expected=1");
    summary();
  end

  initial begin
    bit ack;
    int base;
    void'($urandom(32'h1234_5678));
    wq(5);
    chk("R1 sda_oe in reset", sda_oe, 0);
    chk("R1 scl_oe in reset", scl_oe, 0);
    rst_n = 1'b1;
    wq(4);
    chk("R1 sda_oe after reset", sda_oe, 0);
    chk("R1 scl_oe after reset", scl_oe, 0);
    chk("R1 rx_valid after reset", rx_valid, 0);

    run_txn(OWN, 1'b0, 3, -1);
    run_txn(OWN, 1'b1, 2, -1);          // R3 read direction
    run_txn(OWN ^ 7'h01, 1'b0, 2, -1);  // R3 foreign address
    run_txn(OWN, 1'b0, 4, 1);           // R6 early refusal

    // R7 clock stretching
    base = n_got;
    bus_start();
    send_byte({OWN, 1'b0}, ack);
    chk("R2 ack before stretch", ack, 1);
    rx_ready = 1'b0;
    send_byte(8'hC3, ack);
    chk("R5 ack before stretch", ack, 1);
    chk("R7 SCL held", scl_oe, 1);
    wq(3*Q);
    chk("R7 SCL still held", scl_oe, 1);
    chk("R7 SDA released while holding", sda_oe, 0);
    rx_ready = 1'b1;
    wq(4);
    chk("R7 SCL released", scl_oe, 0);
    send_byte(8'h3C, ack);
    chk("R5 ack after stretch", ack, 1);
    bus_stop();
    chk("R4 count over stretch", n_got - base, 2);
    chk("R4 byte after stretch", got[base + 1], 8'h3C);
    chk("R8 no stretch started in high phase", r8_viol, 0);

    // R9 repeated START in mid byte
    base = n_got;
    bus_start();
    send_byte({OWN, 1'b0}, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_start();
    send_byte({OWN ^ 7'h40, 1'b0}, ack);
    chk("R9 foreign address after restart", ack, 0);
    send_byte(8'hEE, ack);
    chk("R9 byte after foreign restart", ack, 0);
    bus_start();
    send_byte({OWN, 1'b0}, ack);
    chk("R9 own address after restart", ack, 1);
    send_byte(8'hA5, ack);
    chk("R9 byte after restart acked", ack, 1);
    bus_stop();
    chk("R9 only one byte delivered", n_got - base, 1);
    chk("R9 byte value", got[base], 8'hA5);

    // R10 STOP returns to idle
    base = n_got;
    bus_start();
    send_byte({OWN, 1'b0}, ack);
    send_byte(8'h81, ack);
    bus_stop();
    scl_m = 1'b0; wq(Q);
    send_byte(8'h7E, ack);
    chk("R10 byte without START refused", ack, 0);
    bus_stop();
    chk("R10 delivered count", n_got - base, 1);
    chk("R10 byte before STOP", got[base], 8'h81);

    for (int t = 0; t < 10; t++) begin
      logic [6:0] a;
      int nb, li;
      a  = ($urandom % 2) ? OWN : 7'($urandom);
      nb = 1 + int'($urandom % 4);
      li = ($urandom % 3 == 0) ? int'($urandom % nb) : -1;
      run_txn(a, 1'b0, nb, li);
    end
    chk("R8 no stretch started in high phase (final)", r8_viol, 0);
    summary();
  end

endmodule